// File: doc/BRIEF.md
# Auto-Negotiation Status and Setup Register Bank

This block holds two management-visible registers of a 10/100 Ethernet PHY. One is the auto-negotiation expansion register at address 6. The other is a vendor setup register at address 16. The auto-negotiation engine sends it single-cycle event pulses and level inputs. The block turns them into sticky status bits, and each bit has its own clearing rule. Some bits clear when they are read. One bit clears when a different register, address 5, is read. One bit clears on link loss, and one bit mirrors the link-partner ability word. The setup register also holds three read/write control bits that drive outputs into the PHY.

The management side is a parallel port with a 5-bit address, 16-bit write data and separate read and write strobes. The serial management framing sits in front of this port and is not part of the block. Read data is registered: it appears one clock after the read strobe and holds until the next read.

Top module: `an_status_bank`

## Requirements
- R1: After reset, all status bits, all three control outputs and the read data output are 0.
- R2: Address 6 bit 4 (multiple link fault) is set by a `evMultiFault` pulse and stays set until address 6 is read. That read returns 1 in bit 4, and the next read of address 6 returns 0.
- R3: A read of the clearing register in the same cycle as the set event of a sticky bit returns the bit's old value, and the bit stays set afterwards. This holds for address 6 bit 4 and for address 5 reads against bit 1.
- R4: In address 6, bit 3 equals `lpAbility[15]` at the time of the read. Bit 2 and bits 15:5 always read 0.
- R5: Address 6 bit 1 (page received) is set by `evPageRx`. A read of address 5 clears it. A read of address 6 does not clear it.
- R6: `evLinkLost` clears address 6 bit 1. When `evPageRx` and `evLinkLost` arrive in the same cycle, the bit ends up 0.
- R7: Address 6 bit 0 reads the `lpAnKnown` input as it is at the time of the read.
- R8: Address 16 bits 11, 10 and 9 are read/write. They drive `ledLinkPulseSel`, `anTimerFast` and `anLoopback`, and each output changes on the clock edge that takes the write.
- R9: Writes to address 16 bits 15:12 and 8:0 are ignored. Bits 15:12 and 8:3 always read 0.
- R10: Address 16 bits 2, 1 and 0 latch on `stAbilityDetect`, `stParDetFault` and `stLinkCheck` pulses. Only reset or `anRestart` clears them, and `anRestart` wins over a set pulse in the same cycle.
- R11: `mgmtRdData` is loaded on the clock edge that samples `mgmtRd` and holds otherwise. Addresses other than 6 and 16 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evMultiFault | input | 1 | Multiple link fault event pulse |
| evPageRx | input | 1 | Link code word page accepted pulse |
| evLinkLost | input | 1 | Link lost pulse |
| lpAnKnown | input | 1 | Partner known to be auto-negotiation capable |
| stAbilityDetect | input | 1 | Engine entered ability-detect state |
| stParDetFault | input | 1 | Engine entered parallel-detection-fault state |
| stLinkCheck | input | 1 | Engine entered link-status-check state |
| anRestart | input | 1 | Auto-negotiation restart pulse |
| lpAbility | input | 16 | Link-partner ability word (address 5 contents) |
| mgmtAddr | input | 5 | Management register address |
| mgmtWrData | input | 16 | Management write data |
| mgmtRd | input | 1 | Read strobe |
| mgmtWr | input | 1 | Write strobe |
| mgmtRdData | output | 16 | Registered read data |
| ledLinkPulseSel | output | 1 | LED shows link pulses (address 16 bit 11) |
| anTimerFast | output | 1 | Auto-negotiation timer speed-up (bit 10) |
| anLoopback | output | 1 | Auto-negotiation loopback (bit 9) |

## Verification
The bench targets the collisions between set events and clearing actions.

- A fault pulse that arrives in the same cycle as the read of address 6 must come back on the following read. A design that lets the clear win drops the event, and that read returns 0.
- A page pulse that arrives together with a read of address 5 must also survive.
- A page pulse that arrives together with link loss must not survive.
- A restart that arrives together with a state pulse must clear the flag. A design with the priority reversed shows a stale flag.

The bench also checks that a read of address 6 leaves the page bit alone, since a wrong clear source empties it. It checks that all-ones writes to address 16 and to other addresses change nothing beyond bits 11:9, which catches a mask that is too wide. Finally, it checks that read data holds across idle cycles, which catches an unregistered or free-running read mux.

// File: rtl/an_status_pkg.sv
package an_status_pkg;
  // Decoded management access, one strobe per register action
  typedef struct packed {
    logic rdExp;    // read of expansion register
    logic rdLpa;    // read of partner ability register (side effect only)
    logic rdSetup;  // read of setup register
    logic wrSetup;  // write of setup register
    logic rdAny;    // any read: load read data
  } mgmtStrobe_t;

  localparam int FLAG_N = 3;
  localparam int CTRL_N = 3;
endpackage

// File: rtl/an_status_ctrl.sv
module an_status_ctrl
  import an_status_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int LPA_ADDR   = 5,
  parameter int EXP_ADDR   = 6,
  parameter int SETUP_ADDR = 16
) (
  input  logic [ADDR_W-1:0] mgmtAddr,
  input  logic              mgmtRd,
  input  logic              mgmtWr,
  output mgmtStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] LpaSel   = ADDR_W'(LPA_ADDR);
  localparam logic [ADDR_W-1:0] ExpSel   = ADDR_W'(EXP_ADDR);
  localparam logic [ADDR_W-1:0] SetupSel = ADDR_W'(SETUP_ADDR);

  always_comb begin
    strobe.rdExp   = mgmtRd && (mgmtAddr == ExpSel);
    strobe.rdLpa   = mgmtRd && (mgmtAddr == LpaSel);
    strobe.rdSetup = mgmtRd && (mgmtAddr == SetupSel);
    strobe.wrSetup = mgmtWr && (mgmtAddr == SetupSel);
    strobe.rdAny   = mgmtRd;
  end
endmodule

// File: rtl/an_status_data.sv
module an_status_data
  import an_status_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStrobe_t       strobe,
  input  logic              evMultiFault,
  input  logic              evPageRx,
  input  logic              evLinkLost,
  input  logic              lpAnKnown,
  input  logic              lpNextPage,
  input  logic [FLAG_N-1:0] stateHit,
  input  logic              anRestart,
  input  logic [CTRL_N-1:0] ctrlWrBits,
  output logic [DATA_W-1:0] rdData,
  output logic [CTRL_N-1:0] ctrlQ
);
  localparam int ExpPad   = DATA_W - 5;
  localparam int SetupPad = DATA_W - 12;

  logic              multiFault;
  logic              pageRx;
  logic [FLAG_N-1:0] flagQ;
  logic [DATA_W-1:0] expWord;
  logic [DATA_W-1:0] setupWord;
  logic [DATA_W-1:0] rdNext;

  // Sticky fault: a set in the same cycle as the clearing read wins
  always_ff @(posedge clk) begin
    if (!rstN)             multiFault <= 1'b0;
    else if (evMultiFault) multiFault <= 1'b1;
    else if (strobe.rdExp) multiFault <= 1'b0;
  end

  // Page received: link loss beats a new page, a new page beats an ability read
  always_ff @(posedge clk) begin
    if (!rstN)             pageRx <= 1'b0;
    else if (evLinkLost)   pageRx <= 1'b0;
    else if (evPageRx)     pageRx <= 1'b1;
    else if (strobe.rdLpa) pageRx <= 1'b0;
  end

  // State-visited flags, restart has priority over a fresh entry
  for (genvar i = 0; i < FLAG_N; i++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN)            flagQ[i] <= 1'b0;
      else if (anRestart)   flagQ[i] <= 1'b0;
      else if (stateHit[i]) flagQ[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               ctrlQ <= '0;
    else if (strobe.wrSetup) ctrlQ <= ctrlWrBits;
  end

  always_comb begin
    expWord   = {{ExpPad{1'b0}}, multiFault, lpNextPage, 1'b0, pageRx, lpAnKnown};
    setupWord = {{SetupPad{1'b0}}, ctrlQ, 6'b0, flagQ};
    if (strobe.rdExp)        rdNext = expWord;
    else if (strobe.rdSetup) rdNext = setupWord;
    else                     rdNext = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdData <= '0;
    else if (strobe.rdAny) rdData <= rdNext;
  end
endmodule

// File: rtl/an_status_bank.sv
module an_status_bank
  import an_status_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int LPA_ADDR   = 5,
  parameter int EXP_ADDR   = 6,
  parameter int SETUP_ADDR = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evMultiFault,
  input  logic              evPageRx,
  input  logic              evLinkLost,
  input  logic              lpAnKnown,
  input  logic              stAbilityDetect,
  input  logic              stParDetFault,
  input  logic              stLinkCheck,
  input  logic              anRestart,
  input  logic [DATA_W-1:0] lpAbility,
  input  logic [ADDR_W-1:0] mgmtAddr,
  input  logic [DATA_W-1:0] mgmtWrData,
  input  logic              mgmtRd,
  input  logic              mgmtWr,
  output logic [DATA_W-1:0] mgmtRdData,
  output logic              ledLinkPulseSel,
  output logic              anTimerFast,
  output logic              anLoopback
);
  mgmtStrobe_t       strobe;
  logic [CTRL_N-1:0] ctrlQ;

  an_status_ctrl #(
    .ADDR_W(ADDR_W), .LPA_ADDR(LPA_ADDR),
    .EXP_ADDR(EXP_ADDR), .SETUP_ADDR(SETUP_ADDR)
  ) uCtrl (
    .mgmtAddr(mgmtAddr), .mgmtRd(mgmtRd), .mgmtWr(mgmtWr), .strobe(strobe)
  );

  an_status_data #(.DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evMultiFault(evMultiFault), .evPageRx(evPageRx), .evLinkLost(evLinkLost),
    .lpAnKnown(lpAnKnown), .lpNextPage(lpAbility[DATA_W-1]),
    .stateHit({stAbilityDetect, stParDetFault, stLinkCheck}),
    .anRestart(anRestart), .ctrlWrBits(mgmtWrData[11:9]),
    .rdData(mgmtRdData), .ctrlQ(ctrlQ)
  );

  assign ledLinkPulseSel = ctrlQ[2];
  assign anTimerFast     = ctrlQ[1];
  assign anLoopback      = ctrlQ[0];
endmodule

// File: rtl/an_status_chk.sv
module an_status_chk #(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 16,
  parameter int EXP_ADDR   = 6,
  parameter int SETUP_ADDR = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              lpAnKnown,
  input logic [DATA_W-1:0] lpAbility,
  input logic [ADDR_W-1:0] mgmtAddr,
  input logic [DATA_W-1:0] mgmtWrData,
  input logic              mgmtRd,
  input logic              mgmtWr,
  input logic [DATA_W-1:0] mgmtRdData,
  input logic              ledLinkPulseSel,
  input logic              anTimerFast,
  input logic              anLoopback
);
  logic rdExp, rdSetup, wrSetup;
  assign rdExp   = mgmtRd && (mgmtAddr == ADDR_W'(EXP_ADDR));
  assign rdSetup = mgmtRd && (mgmtAddr == ADDR_W'(SETUP_ADDR));
  assign wrSetup = mgmtWr && (mgmtAddr == ADDR_W'(SETUP_ADDR));

  assert_exp_fixed_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdExp |=> (mgmtRdData[DATA_W-1:5] == '0) && !mgmtRdData[2]
              && (mgmtRdData[3] == $past(lpAbility[DATA_W-1])));

  assert_partner_an_R7: assert property (@(posedge clk) disable iff (!rstN)
    rdExp |=> mgmtRdData[0] == $past(lpAnKnown));

  assert_ctrl_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    wrSetup |=> {ledLinkPulseSel, anTimerFast, anLoopback} == $past(mgmtWrData[11:9]));

  assert_ctrl_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    !wrSetup |=> $stable({ledLinkPulseSel, anTimerFast, anLoopback}));

  assert_setup_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdSetup |=> (mgmtRdData[DATA_W-1:12] == '0) && (mgmtRdData[8:3] == '0));

  assert_rd_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    !mgmtRd |=> $stable(mgmtRdData));

  assert_unmapped_R11: assert property (@(posedge clk) disable iff (!rstN)
    (mgmtRd && !rdExp && !rdSetup) |=> mgmtRdData == '0);
endmodule

bind an_status_bank an_status_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .EXP_ADDR(EXP_ADDR), .SETUP_ADDR(SETUP_ADDR)
) uChk (
  .clk(clk), .rstN(rstN), .lpAnKnown(lpAnKnown), .lpAbility(lpAbility),
  .mgmtAddr(mgmtAddr), .mgmtWrData(mgmtWrData), .mgmtRd(mgmtRd), .mgmtWr(mgmtWr),
  .mgmtRdData(mgmtRdData), .ledLinkPulseSel(ledLinkPulseSel),
  .anTimerFast(anTimerFast), .anLoopback(anLoopback)
);

// File: tb/sim_an_status_bank.sv
module sim_an_status_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        evMultiFault = 0, evPageRx = 0, evLinkLost = 0, lpAnKnown = 0;
  logic        stAbilityDetect = 0, stParDetFault = 0, stLinkCheck = 0, anRestart = 0;
  logic [15:0] lpAbility = '0;
  logic [4:0]  mgmtAddr = '0;
  logic [15:0] mgmtWrData = '0;
  logic        mgmtRd = 0, mgmtWr = 0;
  logic [15:0] mgmtRdData;
  logic        ledLinkPulseSel, anTimerFast, anLoopback;

  int checks = 0;
  int errors = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        sampleNext = 0;
  logic        done = 0;

  always #10 clk = ~clk;  // 50 MHz

  an_status_bank u0 (.*);

  // Monitor: a read strobe seen at a rising edge yields data checked at the next falling edge
  always @(posedge clk) sampleNext <= mgmtRd;

  always @(negedge clk) begin
    if (sampleNext && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      checks++;
      if (mgmtRdData !== e) begin
        errors++;
        $display("FAIL %s read data actual %h expected %h", t, mgmtRdData, e);
      end
    end
  end

  // Driver: called at a falling edge; any event inputs are already set by the caller
  task automatic doRead(input logic [4:0] a, input logic [15:0] e, input string t);
    mgmtAddr = a;
    mgmtRd = 1;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    mgmtRd = 0;
  endtask

  task automatic doWrite(input logic [4:0] a, input logic [15:0] d);
    mgmtAddr = a;
    mgmtWrData = d;
    mgmtWr = 1;
    @(negedge clk);
    mgmtWr = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic checkVal(input logic [15:0] act, input logic [15:0] e, input string t);
    checks++;
    if (act !== e) begin
      errors++;
      $display("FAIL %s actual %h expected %h", t, act, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkVal({13'b0, ledLinkPulseSel, anTimerFast, anLoopback}, 16'h0, "R1 control outputs in reset");
    checkVal(mgmtRdData, 16'h0, "R1 read data in reset");
    rstN = 1;
    idle(1);
    doRead(5'd6, 16'h0000, "R1 expansion after reset");
    doRead(5'd16, 16'h0000, "R1 setup after reset");

    lpAbility = 16'h8000;
    doRead(5'd6, 16'h0008, "R4 next-page mirror set");
    lpAbility = 16'h7FFF;
    doRead(5'd6, 16'h0000, "R4 other ability bits do not leak");
    lpAbility = 16'h0000;

    lpAnKnown = 1;
    doRead(5'd6, 16'h0001, "R7 partner AN able");
    lpAnKnown = 0;
    doRead(5'd6, 16'h0000, "R7 partner AN not known");

    evMultiFault = 1; idle(1); evMultiFault = 0;
    doRead(5'd6, 16'h0010, "R2 fault latched");
    doRead(5'd6, 16'h0000, "R2 fault cleared by read");

    evMultiFault = 1;
    doRead(5'd6, 16'h0000, "R3 same-cycle read shows old value");
    evMultiFault = 0;
    doRead(5'd6, 16'h0010, "R3 fault kept after collision");
    doRead(5'd6, 16'h0000, "R2 fault cleared after collision read");

    evPageRx = 1; idle(1); evPageRx = 0;
    doRead(5'd6, 16'h0002, "R5 page received set");
    doRead(5'd6, 16'h0002, "R5 expansion read leaves page bit");
    doRead(5'd5, 16'h0000, "R11 address 5 reads 0 here");
    doRead(5'd6, 16'h0000, "R5 page bit cleared by ability read");

    evPageRx = 1;
    doRead(5'd5, 16'h0000, "R3 ability read with page event");
    evPageRx = 0;
    doRead(5'd6, 16'h0002, "R3 page bit kept after collision");
    evLinkLost = 1; idle(1); evLinkLost = 0;
    doRead(5'd6, 16'h0000, "R6 page bit cleared by link loss");
    evPageRx = 1; evLinkLost = 1; idle(1); evPageRx = 0; evLinkLost = 0;
    doRead(5'd6, 16'h0000, "R6 link loss beats page event");

    doWrite(5'd16, 16'hFFFF);
    checkVal({13'b0, ledLinkPulseSel, anTimerFast, anLoopback}, 16'h0007, "R8 controls after all-ones write");
    doRead(5'd16, 16'h0E00, "R9 only control bits stored");
    doWrite(5'd16, 16'h0400);
    checkVal({13'b0, ledLinkPulseSel, anTimerFast, anLoopback}, 16'h0002, "R8 timer bit only");
    doRead(5'd16, 16'h0400, "R8 setup readback");

    stAbilityDetect = 1; idle(1); stAbilityDetect = 0;
    doRead(5'd16, 16'h0404, "R10 ability-detect flag");
    stParDetFault = 1; stLinkCheck = 1; idle(1); stParDetFault = 0; stLinkCheck = 0;
    doRead(5'd16, 16'h0407, "R10 all flags");
    doWrite(5'd16, 16'h0400);
    doRead(5'd16, 16'h0407, "R9 write does not clear flags");
    anRestart = 1; idle(1); anRestart = 0;
    doRead(5'd16, 16'h0400, "R10 restart clears flags");
    anRestart = 1; stLinkCheck = 1; idle(1); anRestart = 0; stLinkCheck = 0;
    doRead(5'd16, 16'h0400, "R10 restart beats entry");

    doWrite(5'd6, 16'hFFFF);
    doWrite(5'd3, 16'hFFFF);
    checkVal({13'b0, ledLinkPulseSel, anTimerFast, anLoopback}, 16'h0002, "R11 other-address writes ignored");
    doRead(5'd6, 16'h0000, "R11 expansion unchanged by write");
    doRead(5'd31, 16'h0000, "R11 unmapped address");
    doRead(5'd16, 16'h0400, "R11 setup before hold");
    idle(4);
    checkVal(mgmtRdData, 16'h0400, "R11 read data holds while idle");

    idle(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog run did not complete actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule